// File: doc/BRIEF.md
# Flash Mode-Dependent Read Multiplexer

This block sits on the read path of a parallel NOR flash model. A separate command sequencer tracks the unlock and command cycles and reports the current command mode. On every read strobe, this multiplexer uses that mode to pick the word to return. The choices are array contents, a manufacturer or device identification word, a sector-protect indication, the busy status byte with its toggling bit, or one byte of the common flash query table. The query table is computed at elaboration from the sector geometry. Each read is registered, so data appears one clock after the strobe and then holds.

The block also tracks whether the device should still decode reads through the command logic or can go back to plain array mapping. A write seen while the sequencer is idle turns that mapping off and clears a read counter. Once enough further idle reads have gone by, the mapping is restored. The device width (1, 2 or 4 bytes) and the byte order of multi-byte array reads are static parameters.

Top module: `flash_read_mux`

## Requirements
- R1: In idle mode (code 0), erase-armed mode (code 1) and the unused code 7, a read returns the array word at the masked read address. Array byte lane k holds the byte at address+k.
- R2: With BIG_ENDIAN set, the byte at the lowest address is placed in the most significant byte of the read data. With BIG_ENDIAN clear, it is placed in the least significant byte.
- R3: In identification mode (code 2), offset 0 returns ID word 0 and offset 1 returns ID word 1. Offset 2 returns zero, meaning no sector is protected.
- R4: In identification mode, offset 0x0E returns ID word 2 and offset 0x0F returns ID word 3. An ID word equal to 0x00FF is replaced by the array word. Every other offset also returns the array word.
- R5: In program (code 3), sector-erase (code 4) and chip-erase (code 5) modes, a read returns the status byte with bit 6 XORed by an internal toggle. The toggle is 0 after reset and inverts after each such read.
- R6: In query mode (code 6), offsets 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Offset 0x27 returns log2 of the chip size in bytes. Offset 0x2D returns the low byte of sector count minus one. Offset 0x2F returns sector size bits 15:8. Any offset above 0x52 returns zero.
- R7: The identification and query offset is read address bits 7:0 shifted right by log2(DEV_BYTES). Higher address bits are ignored.
- R8: After reset, direct_map is 1. A write strobe while seq_idle is high clears direct_map in the next cycle. After that, the read that brings the idle-read count above REMAP_LIMIT (42 by default) sets direct_map again.
- R9: A write strobe while seq_idle is high restarts the idle-read count from zero.
- R10: Read data changes only in the cycle after a read strobe and holds otherwise. It is zero after reset.
- R11: Reads and writes while seq_idle is low neither advance the idle-read count nor change direct_map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_code | input | 3 | Command mode from the sequencer |
| seq_idle | input | 1 | Sequencer is at its first write cycle with no command under way |
| rd_valid | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| wr_strobe | input | 1 | A bus write reached the device |
| id_word0 | input | DEV_BYTES*8 | Manufacturer ID |
| id_word1 | input | DEV_BYTES*8 | Device ID |
| id_word2 | input | DEV_BYTES*8 | Extended device ID, 0x00FF means absent |
| id_word3 | input | DEV_BYTES*8 | Extended device ID, 0x00FF means absent |
| status_in | input | 8 | Busy status byte from the sequencer |
| arr_addr | output | ADDR_W | Array read address, masked to the chip size |
| arr_rdata | input | DEV_BYTES*8 | Array bytes at arr_addr, lane k from address+k |
| rd_data | output | DEV_BYTES*8 | Registered read data |
| direct_map | output | 1 | Array may be read without command decoding |

## Verification
The bench goes after a few specific corner cases. The first is the fallback when an extended ID word holds 0x00FF; a design that ignored it would return 0x00FF instead of array data. Next is the boundary of the query table, where a design off by one or indexing past the table would return stale data for high offsets. Odd byte addresses and high address bits in query and identification reads catch a design that skipped the width shift or the 8-bit truncation. The toggle bit is followed across a change between busy modes, which exposes a toggle that restarts per mode or flips on non-status reads. Finally, the restore of direct mapping is probed one read before and exactly at the limit, with a restart in the middle and reads while the sequencer is busy. A counter that is off by one, never cleared, or counting while busy would flip direct_map at the wrong read.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

   typedef enum logic [2:0] {
      FMR_IDLE       = 3'd0,
      FMR_ERASE_ARM  = 3'd1,
      FMR_IDENT      = 3'd2,
      FMR_PROG       = 3'd3,
      FMR_SECT_ERASE = 3'd4,
      FMR_CHIP_ERASE = 3'd5,
      FMR_QUERY      = 3'd6,
      FMR_RSVD       = 3'd7
   } fmr_mode_e;

   typedef enum logic [2:0] {
      SRC_ARRAY,
      SRC_ID,
      SRC_ZERO,
      SRC_STATUS,
      SRC_QUERY
   } fmr_src_e;

   // highest offset that belongs to the query table
   localparam int unsigned QUERY_LAST = 'h52;
   localparam int unsigned QUERY_SLOTS = 256;

   // one byte of the query table for the given geometry
   function automatic logic [7:0] query_entry(int unsigned idx,
                                              int unsigned sect_bytes,
                                              int unsigned n_sect,
                                              int unsigned chip_log2);
      logic [7:0] v;
      v = 8'h00;
      case (idx)
         'h10: v = 8'h51;
         'h11: v = 8'h52;
         'h12: v = 8'h59;
         'h13: v = 8'h02;
         'h15: v = 8'h31;
         'h1B: v = 8'h27;
         'h1C: v = 8'h36;
         'h1F: v = 8'h07;
         'h21: v = 8'h09;
         'h22: v = 8'h0C;
         'h23: v = 8'h01;
         'h25: v = 8'h0A;
         'h26: v = 8'h0D;
         'h27: v = 8'(chip_log2);
         'h28: v = 8'h02;
         'h2C: v = 8'h01;
         'h2D: v = 8'(n_sect - 1);
         'h2E: v = 8'((n_sect - 1) >> 8);
         'h2F: v = 8'(sect_bytes >> 8);
         'h30: v = 8'(sect_bytes >> 16);
         'h31: v = 8'h50;
         'h32: v = 8'h52;
         'h33: v = 8'h49;
         'h34: v = 8'h31;
         'h35: v = 8'h30;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/fmr_query_rom.sv
module fmr_query_rom
   import fmr_pkg::*;
#(
   parameter int unsigned SECTOR_BYTES = 4096,
   parameter int unsigned NUM_SECTORS  = 16
) (
   input  logic [7:0] idx,
   output logic [7:0] value
);
   localparam int unsigned CHIP_BYTES = SECTOR_BYTES * NUM_SECTORS;
   localparam int unsigned CHIP_LOG2  = $clog2(CHIP_BYTES);

   logic [7:0] rom [0:QUERY_SLOTS-1];

   // slots above the table end are tied to zero
   for (genvar g = 0; g < QUERY_SLOTS; g++) begin : g_slot
      if (g > QUERY_LAST) begin : g_blank
         assign rom[g] = 8'h00;
      end else begin : g_entry
         localparam logic [7:0] ENTRY =
            query_entry(g, SECTOR_BYTES, NUM_SECTORS, CHIP_LOG2);
         assign rom[g] = ENTRY;
      end
   end

   assign value = rom[idx];

endmodule

// File: rtl/fmr_lane_order.sv
module fmr_lane_order #(
   parameter int unsigned DEV_BYTES  = 2,
   parameter bit          BIG_ENDIAN = 1'b0
) (
   input  logic [DEV_BYTES*8-1:0] lanes_in,
   output logic [DEV_BYTES*8-1:0] word_out
);
   for (genvar k = 0; k < DEV_BYTES; k++) begin : g_lane
      if (BIG_ENDIAN) begin : g_big
         assign word_out[(DEV_BYTES-1-k)*8 +: 8] = lanes_in[k*8 +: 8];
      end else begin : g_little
         assign word_out[k*8 +: 8] = lanes_in[k*8 +: 8];
      end
   end
endmodule

// File: rtl/fmr_remap_ctr.sv
module fmr_remap_ctr #(
   parameter int unsigned REMAP_LIMIT = 42
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_valid,
   input  logic wr_strobe,
   input  logic seq_idle,
   output logic direct_map
);
   localparam int unsigned CNT_W = $clog2(REMAP_LIMIT + 1);

   logic [CNT_W-1:0] idle_reads;
   logic             map_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_reads <= '0;
         map_q      <= 1'b1;
      end else if (wr_strobe && seq_idle) begin
         idle_reads <= '0;
         map_q      <= 1'b0;
      end else if (rd_valid && seq_idle && !map_q) begin
         if (idle_reads == CNT_W'(REMAP_LIMIT)) begin
            map_q <= 1'b1;
         end else begin
            idle_reads <= idle_reads + 1'b1;
         end
      end
   end

   assign direct_map = map_q;

   // a write with the sequencer idle always drops direct mapping
   assert_write_unmaps_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && seq_idle) |=> !direct_map);

   // mapping comes back only on an idle read
   assert_restore_on_read_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(direct_map) |-> $past(rd_valid && seq_idle));

   // nothing moves the mapping while the sequencer is busy
   assert_busy_frozen_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !seq_idle |=> $stable(direct_map));

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
   import fmr_pkg::*;
#(
   parameter int unsigned DEV_BYTES    = 2,
   parameter bit          BIG_ENDIAN   = 1'b0,
   parameter int unsigned SECTOR_BYTES = 4096,
   parameter int unsigned NUM_SECTORS  = 16,
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned REMAP_LIMIT  = 42
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:0]             mode_code,
   input  logic                   seq_idle,
   input  logic                   rd_valid,
   input  logic [ADDR_W-1:0]      rd_addr,
   input  logic                   wr_strobe,
   input  logic [DEV_BYTES*8-1:0] id_word0,
   input  logic [DEV_BYTES*8-1:0] id_word1,
   input  logic [DEV_BYTES*8-1:0] id_word2,
   input  logic [DEV_BYTES*8-1:0] id_word3,
   input  logic [7:0]             status_in,
   output logic [ADDR_W-1:0]      arr_addr,
   input  logic [DEV_BYTES*8-1:0] arr_rdata,
   output logic [DEV_BYTES*8-1:0] rd_data,
   output logic                   direct_map
);
   localparam int unsigned DATA_W     = DEV_BYTES * 8;
   localparam int unsigned LANE_SHIFT = $clog2(DEV_BYTES);
   localparam int unsigned CHIP_BYTES = SECTOR_BYTES * NUM_SECTORS;
   localparam int unsigned CHIP_AW    = $clog2(CHIP_BYTES);
   localparam logic [DATA_W-1:0] ID_ABSENT = DATA_W'(8'hFF);

   // elaboration-time parameter checks
   if (DEV_BYTES != 1 && DEV_BYTES != 2 && DEV_BYTES != 4) begin : g_bad_width
      $error("flash_read_mux: DEV_BYTES must be 1, 2 or 4");
   end
   if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0 || SECTOR_BYTES < 256) begin : g_bad_sector
      $error("flash_read_mux: SECTOR_BYTES must be a power of two of at least 256");
   end
   if (ADDR_W < CHIP_AW || ADDR_W < 8) begin : g_bad_addr
      $error("flash_read_mux: ADDR_W too narrow for the chip");
   end
   if (REMAP_LIMIT < 1) begin : g_bad_limit
      $error("flash_read_mux: REMAP_LIMIT must be positive");
   end

   // array address wraps at the chip size
   if (ADDR_W > CHIP_AW) begin : g_mask
      assign arr_addr = {{(ADDR_W-CHIP_AW){1'b0}}, rd_addr[CHIP_AW-1:0]};
   end else begin : g_nomask
      assign arr_addr = rd_addr;
   end

   logic [7:0]        idx;
   logic [7:0]        query_byte;
   logic [DATA_W-1:0] array_word;
   fmr_mode_e         mode;
   fmr_src_e          src;
   logic [DATA_W-1:0] id_pick;
   logic [DATA_W-1:0] next_data;
   logic              toggle_q;

   assign idx  = 8'(rd_addr[7:0] >> LANE_SHIFT);
   assign mode = fmr_mode_e'(mode_code);

   fmr_query_rom #(
      .SECTOR_BYTES (SECTOR_BYTES),
      .NUM_SECTORS  (NUM_SECTORS)
   ) u_query (
      .idx   (idx),
      .value (query_byte)
   );

   fmr_lane_order #(
      .DEV_BYTES  (DEV_BYTES),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_lanes (
      .lanes_in (arr_rdata),
      .word_out (array_word)
   );

   fmr_remap_ctr #(
      .REMAP_LIMIT (REMAP_LIMIT)
   ) u_remap (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_valid   (rd_valid),
      .wr_strobe  (wr_strobe),
      .seq_idle   (seq_idle),
      .direct_map (direct_map)
   );

   // source selection by mode and offset
   always_comb begin
      src     = SRC_ARRAY;
      id_pick = id_word0;
      unique case (mode)
         FMR_IDENT: begin
            case (idx)
               8'h00: src = SRC_ID;
               8'h01: begin
                  src     = SRC_ID;
                  id_pick = id_word1;
               end
               8'h02: src = SRC_ZERO;
               8'h0E: begin
                  id_pick = id_word2;
                  src     = (id_word2 == ID_ABSENT) ? SRC_ARRAY : SRC_ID;
               end
               8'h0F: begin
                  id_pick = id_word3;
                  src     = (id_word3 == ID_ABSENT) ? SRC_ARRAY : SRC_ID;
               end
               default: src = SRC_ARRAY;
            endcase
         end
         FMR_PROG, FMR_SECT_ERASE, FMR_CHIP_ERASE: src = SRC_STATUS;
         FMR_QUERY: src = SRC_QUERY;
         default: src = SRC_ARRAY;
      endcase
   end

   always_comb begin
      case (src)
         SRC_ID:     next_data = id_pick;
         SRC_ZERO:   next_data = '0;
         SRC_STATUS: next_data = DATA_W'({status_in[7], status_in[6] ^ toggle_q,
                                          status_in[5:0]});
         SRC_QUERY:  next_data = DATA_W'(query_byte);
         default:    next_data = array_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         toggle_q <= 1'b0;
      end else if (rd_valid) begin
         rd_data <= next_data;
         if (src == SRC_STATUS) begin
            toggle_q <= !toggle_q;
         end
      end
   end

   // output holds between reads
   assert_hold_idle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> $stable(rd_data));

   // every busy-mode read flips the toggle
   assert_toggle_flip_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && (mode == FMR_PROG || mode == FMR_SECT_ERASE ||
                    mode == FMR_CHIP_ERASE)) |=> (toggle_q != $past(toggle_q)));

   // non-status reads leave the toggle alone
   assert_toggle_keep_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && (mode == FMR_IDLE || mode == FMR_QUERY || mode == FMR_IDENT))
      |=> $stable(toggle_q));

   // query reads past the table are zero
   assert_query_tail_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && mode == FMR_QUERY && idx > 8'(QUERY_LAST)) |=> (rd_data == '0));

   // protect query reports no protection
   assert_unprotected_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && mode == FMR_IDENT && idx == 8'h02) |=> (rd_data == '0));

endmodule

// File: tb/flash_read_mux_test.sv
`timescale 1ns/1ps
module flash_read_mux_test;

   localparam int unsigned DEV_BYTES = 2;
   localparam int unsigned DW        = DEV_BYTES * 8;
   localparam int unsigned AW        = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode_code = 3'd0;
   logic          seq_idle = 1'b1;
   logic          rd_valid = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          wr_strobe = 1'b0;
   logic [DW-1:0] id_word0 = 16'h0001;
   logic [DW-1:0] id_word1 = 16'h227E;
   logic [DW-1:0] id_word2 = 16'h2210;
   logic [DW-1:0] id_word3 = 16'h00FF;
   logic [7:0]    status_in = 8'h80;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_rdata;
   logic [DW-1:0] rd_data;
   logic          direct_map;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   // array model: byte at address a
   function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hC3;
   endfunction

   // big-endian word expected for byte address a
   function automatic logic [15:0] big_word(logic [AW-1:0] a);
      return {mem_byte(a), mem_byte(a + 16'd1)};
   endfunction

   assign arr_rdata = {mem_byte(arr_addr + 16'd1), mem_byte(arr_addr)};

   flash_read_mux #(
      .DEV_BYTES    (DEV_BYTES),
      .BIG_ENDIAN   (1'b1),
      .SECTOR_BYTES (4096),
      .NUM_SECTORS  (16),
      .ADDR_W       (AW),
      .REMAP_LIMIT  (42)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_code  (mode_code),
      .seq_idle   (seq_idle),
      .rd_valid   (rd_valid),
      .rd_addr    (rd_addr),
      .wr_strobe  (wr_strobe),
      .id_word0   (id_word0),
      .id_word1   (id_word1),
      .id_word2   (id_word2),
      .id_word3   (id_word3),
      .status_in  (status_in),
      .arr_addr   (arr_addr),
      .arr_rdata  (arr_rdata),
      .rd_data    (rd_data),
      .direct_map (direct_map)
   );

   // vector layout: {req[3:0], mode[2:0], addr[15:0], expected[15:0]}
   localparam int NV = 20;
   localparam logic [38:0] VEC [0:NV-1] = '{
      {4'd1, 3'd0, 16'h0100, big_word(16'h0100)},  // R1 idle
      {4'd1, 3'd1, 16'h0234, big_word(16'h0234)},  // R1 erase armed
      {4'd1, 3'd7, 16'h0F02, big_word(16'h0F02)},  // R1 unused code
      {4'd2, 3'd0, 16'hA5C0, big_word(16'hA5C0)},  // R2 byte order
      {4'd3, 3'd2, 16'h0000, 16'h0001},            // R3 id 0
      {4'd3, 3'd2, 16'h0002, 16'h227E},            // R3 id 1
      {4'd3, 3'd2, 16'h0004, 16'h0000},            // R3 protect
      {4'd4, 3'd2, 16'h001C, 16'h2210},            // R4 id 2
      {4'd4, 3'd2, 16'h001E, big_word(16'h001E)},  // R4 absent id 3
      {4'd4, 3'd2, 16'h0010, big_word(16'h0010)},  // R4 other offset
      {4'd6, 3'd6, 16'h0020, 16'h0051},            // R6 Q
      {4'd6, 3'd6, 16'h0022, 16'h0052},            // R6 R
      {4'd6, 3'd6, 16'h0024, 16'h0059},            // R6 Y
      {4'd6, 3'd6, 16'h004E, 16'h0010},            // R6 chip log2
      {4'd6, 3'd6, 16'h005A, 16'h000F},            // R6 sectors-1
      {4'd6, 3'd6, 16'h005E, 16'h0010},            // R6 sector size
      {4'd6, 3'd6, 16'h00AC, 16'h0000},            // R6 beyond table
      {4'd7, 3'd6, 16'h0120, 16'h0051},            // R7 high bits ignored
      {4'd7, 3'd2, 16'h0101, 16'h0001},            // R7 odd byte address
      {4'd7, 3'd6, 16'h00A5, 16'h0000}             // R7 shift to 0x52 boundary
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_read(logic [2:0] m, logic [AW-1:0] a);
      @(negedge clk);
      mode_code = m;
      rd_addr   = a;
      rd_valid  = 1'b1;
      @(negedge clk);
      rd_valid  = 1'b0;
   endtask

   task automatic do_write();
      @(negedge clk);
      wr_strobe = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL R10 actual=watchdog_timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R10 reset data", 32'(rd_data), 32'h0);
      check("R8 reset direct_map", 32'(direct_map), 32'h1);

      for (int i = 0; i < NV; i++) begin
         do_read(VEC[i][34:32], VEC[i][31:16]);
         check($sformatf("R%0d vector %0d", VEC[i][38:35], i),
               32'(rd_data), 32'(VEC[i][15:0]));
      end

      // R10: output holds without a strobe
      held = rd_data;
      @(negedge clk);
      mode_code = 3'd2;
      rd_addr   = 16'h0000;
      repeat (3) @(negedge clk);
      check("R10 hold", 32'(rd_data), 32'(held));

      // R5: toggle across busy modes
      status_in = 8'h80;
      do_read(3'd3, 16'h0000);
      check("R5 program first", 32'(rd_data), 32'h0080);
      do_read(3'd3, 16'h0000);
      check("R5 program second", 32'(rd_data), 32'h00C0);
      do_read(3'd3, 16'h0000);
      check("R5 program third", 32'(rd_data), 32'h0080);
      status_in = 8'h00;
      do_read(3'd0, 16'h0040);   // array read must not flip the toggle
      do_read(3'd4, 16'h1000);
      check("R5 sector erase", 32'(rd_data), 32'h0040);
      do_read(3'd5, 16'h0000);
      check("R5 chip erase", 32'(rd_data), 32'h0000);

      // R8 / R9 / R11: lazy restore of direct mapping
      seq_idle = 1'b1;
      do_write();
      check("R8 write clears direct_map", 32'(direct_map), 32'h0);
      for (int i = 0; i < 30; i++) do_read(3'd0, 16'(i));
      check("R8 still unmapped after 30", 32'(direct_map), 32'h0);
      do_write();  // R9 restart
      for (int i = 0; i < 42; i++) do_read(3'd0, 16'(i));
      check("R9 unmapped after restart plus 42", 32'(direct_map), 32'h0);
      seq_idle = 1'b0;
      for (int i = 0; i < 5; i++) do_read(3'd0, 16'(i));
      do_write();
      check("R11 busy reads and write ignored", 32'(direct_map), 32'h0);
      seq_idle = 1'b1;
      do_read(3'd0, 16'h0000);
      check("R8 restored on read 43", 32'(direct_map), 32'h1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule